// File: doc/BRIEF.md
# On-Chip Data Window Access Router

This block steers an 8051-style core's external data-memory transfers (MOVX) to one of two places. The first is an on-chip window at the top of the 64 KB data space, which holds a peripheral page (`can_sel`) and a RAM area (`ram_sel`). The second is the external bus. A control register in the special-function space (address B1h by default) holds two mapping bits. Bit 0 is a window disable. It comes out of reset at 1 and software can only clear it. Bit 1 chooses whether on-chip transfers are mirrored onto the external strobes and the address/data ports.

Each request is taken on a clock edge and answered for exactly one cycle by a four-state access machine. The states are IDLE, EXT (external bus), INT (on-chip, quiet bus) and MIR (on-chip, mirrored onto the bus). Every state returns to IDLE when no request is present. A new request moves any state, IDLE included, to EXT, INT or MIR according to the decode. A request for an address below the window, or any request while bit 0 is set, goes to EXT. An in-window request with bit 1 = 0 goes to INT. An in-window request with bit 1 = 1 goes to MIR.

Top module: `xram_router`

## Requirements
- R1: After reset the control register reads 01h at address B1h. No target select is active, both external strobes are high (inactive) and the bus drive enable is low.
- R2: A register write at B1h stores bits 6..2 and reads them back unchanged. Bit 7 always reads 0. A read at any other SFR address returns 00h, and a write to another address leaves the register unchanged.
- R3: Once bit 0 has been cleared, writing 1 to it leaves it at 0. Only reset returns it to 1.
- R4: While bit 0 is 1, every MOVX transfer goes to the external bus: `ext_rd_n` or `ext_wr_n` goes low, `ext_oe` is high, no target select is active, and read data comes from `ext_din`. This holds for in-window addresses too.
- R5: While bit 0 is 0, addresses F700h–F7FFh assert `can_sel` and addresses F800h–FFFFh assert `ram_sel`. With bit 1 = 0, both strobes stay high and `ext_oe` stays low during these transfers.
- R6: While bit 0 is 0, addresses below F700h (F6FFh included) go to the external bus.
- R7: With bit 0 = 0 and bit 1 = 1, an in-window transfer selects its on-chip target and also drives the matching strobe low. It raises `ext_oe` and drives the address on `ext_addr` and the write data on `ext_dout`. Read data still comes from the on-chip target.
- R8: Bit 1 changes nothing for addresses outside the window, or while bit 0 is 1.
- R9: A request sampled at clock edge k produces its select, strobe and read-data outputs during the cycle after edge k only. With no request, the next cycle is idle.
- R10: During an on-chip write, `tgt_we` is high, `tgt_wdata` carries the request's data and `tgt_addr` carries its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for write and read |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Register read data, 00h unless the address matches |
| mx_req | input | 1 | MOVX request, one cycle per transfer |
| mx_we | input | 1 | 1 = write, 0 = read |
| mx_addr | input | 16 | MOVX address |
| mx_wdata | input | 8 | MOVX write data |
| mx_rdata | output | 8 | MOVX read data during the access cycle |
| ram_sel | output | 1 | On-chip RAM selected |
| can_sel | output | 1 | On-chip peripheral page selected |
| tgt_we | output | 1 | On-chip write enable |
| tgt_addr | output | 16 | On-chip target address |
| tgt_wdata | output | 8 | On-chip write data |
| ram_rdata | input | 8 | Read data from the RAM target |
| can_rdata | input | 8 | Read data from the peripheral target |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |
| ext_oe | output | 1 | External address/data ports driven |
| ext_addr | output | 16 | External address |
| ext_dout | output | 8 | External write data |
| ext_din | input | 8 | External read data |

## Verification
A register write lands on the clock edge, so `sfr_rdata` is compared on the following low clock phase. A MOVX request is presented half a cycle before the edge that accepts it. Every access output is compared on the low phase that follows that edge, which is one register stage later. The bench then lets one more edge pass with the request removed and checks the idle values, which confirms that the access lasts a single cycle. All inputs change on the falling edge, so no sample is taken at an active edge.

// File: rtl/xram_router_pkg.sv
package xram_router_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int SFR_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXT  = 2'd1,
        ST_INT  = 2'd2,
        ST_MIR  = 2'd3
    } acc_state_e;

    typedef enum logic [1:0] {
        RGN_OUT = 2'd0,
        RGN_CAN = 2'd1,
        RGN_RAM = 2'd2
    } region_e;

    typedef struct packed {
        logic              we;
        logic              is_can;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } acc_req_t;

endpackage

// File: rtl/xr_ctrl_reg.sv
module xr_ctrl_reg
    import xram_router_pkg::*;
#(
    parameter logic [SFR_W-1:0] REG_ADDR  = 8'hB1,
    parameter logic [SFR_W-1:0] KEEP_MASK = 8'h7C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SFR_W-1:0] addr,
    input  logic [SFR_W-1:0] wdata,
    output logic [SFR_W-1:0] rdata,
    output logic             win_dis,
    output logic             mirror_en
);
    localparam int HI_W = SFR_W - 2;

    logic            hit;
    logic            dis_q;
    logic            mir_q;
    logic [HI_W-1:0] hi_q;

    assign hit = we && (addr == REG_ADDR);

    // bit 0: cleared by software only, set by reset only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dis_q <= 1'b1;
        end else if (hit) begin
            dis_q <= dis_q & wdata[0];
        end
    end

    // bit 1: plain read/write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mir_q <= 1'b0;
        end else if (hit) begin
            mir_q <= wdata[1];
        end
    end

    // upper bits: storage only where the mask asks for it
    for (genvar gi = 0; gi < HI_W; gi++) begin : g_hi
        if (KEEP_MASK[gi+2]) begin : g_store
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hi_q[gi] <= 1'b0;
                end else if (hit) begin
                    hi_q[gi] <= wdata[gi+2];
                end
            end
        end else begin : g_tie
            assign hi_q[gi] = 1'b0;
        end
    end

    assign win_dis   = dis_q;
    assign mirror_en = mir_q;
    assign rdata     = (addr == REG_ADDR) ? {hi_q, mir_q, dis_q} : '0;

endmodule

// File: rtl/xr_decode.sv
module xr_decode
    import xram_router_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hF700,
    parameter logic [ADDR_W-1:0] RAM_BASE = 16'hF800
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    always_comb begin
        if (addr >= RAM_BASE) begin
            region = RGN_RAM;
        end else if (addr >= WIN_BASE) begin
            region = RGN_CAN;
        end else begin
            region = RGN_OUT;
        end
    end

endmodule

// File: rtl/xr_access_fsm.sv
module xr_access_fsm
    import xram_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  region_e           region,
    input  logic              win_dis,
    input  logic              mirror_en,
    output logic              ram_sel,
    output logic              can_sel,
    output logic              tgt_we,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic              ext_oe,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_dout,
    output logic              src_int,
    output logic              src_can
);
    acc_state_e st_q, st_d;
    acc_req_t   hold_q, hold_d;

    // next-state decision
    always_comb begin
        st_d = ST_IDLE;
        if (req) begin
            if (win_dis || (region == RGN_OUT)) begin
                st_d = ST_EXT;
            end else if (mirror_en) begin
                st_d = ST_MIR;
            end else begin
                st_d = ST_INT;
            end
        end
    end

    always_comb begin
        hold_d        = hold_q;
        if (req) begin
            hold_d.we     = req_we;
            hold_d.is_can = (region == RGN_CAN);
            hold_d.addr   = req_addr;
            hold_d.wdata  = req_wdata;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            hold_q <= '0;
        end else begin
            st_q   <= st_d;
            hold_q <= hold_d;
        end
    end

    // outputs per state
    always_comb begin
        ram_sel   = 1'b0;
        can_sel   = 1'b0;
        tgt_we    = 1'b0;
        tgt_addr  = '0;
        tgt_wdata = '0;
        ext_rd_n  = 1'b1;
        ext_wr_n  = 1'b1;
        ext_oe    = 1'b0;
        ext_addr  = '0;
        ext_dout  = '0;
        src_int   = 1'b0;
        src_can   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
            end
            ST_EXT: begin
                ext_rd_n = hold_q.we;
                ext_wr_n = !hold_q.we;
                ext_oe   = 1'b1;
                ext_addr = hold_q.addr;
                ext_dout = hold_q.we ? hold_q.wdata : '0;
            end
            ST_INT: begin
                ram_sel   = !hold_q.is_can;
                can_sel   = hold_q.is_can;
                tgt_we    = hold_q.we;
                tgt_addr  = hold_q.addr;
                tgt_wdata = hold_q.we ? hold_q.wdata : '0;
                src_int   = 1'b1;
                src_can   = hold_q.is_can;
            end
            ST_MIR: begin
                ram_sel   = !hold_q.is_can;
                can_sel   = hold_q.is_can;
                tgt_we    = hold_q.we;
                tgt_addr  = hold_q.addr;
                tgt_wdata = hold_q.we ? hold_q.wdata : '0;
                src_int   = 1'b1;
                src_can   = hold_q.is_can;
                ext_rd_n  = hold_q.we;
                ext_wr_n  = !hold_q.we;
                ext_oe    = 1'b1;
                ext_addr  = hold_q.addr;
                ext_dout  = hold_q.we ? hold_q.wdata : '0;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/xram_router.sv
module xram_router
    import xram_router_pkg::*;
#(
    parameter logic [SFR_W-1:0]  REG_ADDR  = 8'hB1,
    parameter logic [SFR_W-1:0]  KEEP_MASK = 8'h7C,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hF700,
    parameter logic [ADDR_W-1:0] RAM_BASE  = 16'hF800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_we,
    input  logic [SFR_W-1:0]  sfr_addr,
    input  logic [SFR_W-1:0]  sfr_wdata,
    output logic [SFR_W-1:0]  sfr_rdata,
    input  logic              mx_req,
    input  logic              mx_we,
    input  logic [ADDR_W-1:0] mx_addr,
    input  logic [DATA_W-1:0] mx_wdata,
    output logic [DATA_W-1:0] mx_rdata,
    output logic              ram_sel,
    output logic              can_sel,
    output logic              tgt_we,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] can_rdata,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic              ext_oe,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_dout,
    input  logic [DATA_W-1:0] ext_din
);
    logic    win_dis;
    logic    mirror_en;
    region_e region;
    logic    src_int;
    logic    src_can;

    xr_ctrl_reg #(
        .REG_ADDR  (REG_ADDR),
        .KEEP_MASK (KEEP_MASK)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (sfr_we),
        .addr      (sfr_addr),
        .wdata     (sfr_wdata),
        .rdata     (sfr_rdata),
        .win_dis   (win_dis),
        .mirror_en (mirror_en)
    );

    xr_decode #(
        .WIN_BASE (WIN_BASE),
        .RAM_BASE (RAM_BASE)
    ) u_dec (
        .addr   (mx_addr),
        .region (region)
    );

    xr_access_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (mx_req),
        .req_we    (mx_we),
        .req_addr  (mx_addr),
        .req_wdata (mx_wdata),
        .region    (region),
        .win_dis   (win_dis),
        .mirror_en (mirror_en),
        .ram_sel   (ram_sel),
        .can_sel   (can_sel),
        .tgt_we    (tgt_we),
        .tgt_addr  (tgt_addr),
        .tgt_wdata (tgt_wdata),
        .ext_rd_n  (ext_rd_n),
        .ext_wr_n  (ext_wr_n),
        .ext_oe    (ext_oe),
        .ext_addr  (ext_addr),
        .ext_dout  (ext_dout),
        .src_int   (src_int),
        .src_can   (src_can)
    );

    // read data source: on-chip target wins even when mirrored
    always_comb begin
        if (src_int) begin
            mx_rdata = src_can ? can_rdata : ram_rdata;
        end else if (!ext_rd_n) begin
            mx_rdata = ext_din;
        end else begin
            mx_rdata = '0;
        end
    end

endmodule

// File: rtl/xram_router_chk.sv
module xram_router_chk (
    input logic clk,
    input logic rst_n,
    input logic mx_req,
    input logic win_dis,
    input logic mirror_en,
    input logic ram_sel,
    input logic can_sel,
    input logic ext_rd_n,
    input logic ext_wr_n
);
    AST_DIS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !win_dis |=> !win_dis); // R3

    AST_DIS_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (mx_req && win_dis) |=> (!ram_sel && !can_sel)); // R4

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (mx_req && !win_dis && !mirror_en) |=> (!(ram_sel || can_sel) || (ext_rd_n && ext_wr_n))); // R5

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_sel, can_sel})); // R5

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rd_n || ext_wr_n)); // R7

    AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mx_req |=> (!ram_sel && !can_sel && ext_rd_n && ext_wr_n)); // R9

endmodule

bind xram_router xram_router_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mx_req    (mx_req),
    .win_dis   (win_dis),
    .mirror_en (mirror_en),
    .ram_sel   (ram_sel),
    .can_sel   (can_sel),
    .ext_rd_n  (ext_rd_n),
    .ext_wr_n  (ext_wr_n)
);

// File: tb/xram_router_tb.sv
module xram_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        mx_req = 1'b0;
    logic        mx_we = 1'b0;
    logic [15:0] mx_addr = 16'h0000;
    logic [7:0]  mx_wdata = 8'h00;
    logic [7:0]  mx_rdata;
    logic        ram_sel, can_sel, tgt_we;
    logic [15:0] tgt_addr;
    logic [7:0]  tgt_wdata;
    logic [7:0]  ram_rdata = 8'hA5;
    logic [7:0]  can_rdata = 8'h3C;
    logic        ext_rd_n, ext_wr_n, ext_oe;
    logic [15:0] ext_addr;
    logic [7:0]  ext_dout;
    logic [7:0]  ext_din = 8'h5A;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    xram_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .mx_req(mx_req), .mx_we(mx_we), .mx_addr(mx_addr), .mx_wdata(mx_wdata), .mx_rdata(mx_rdata),
        .ram_sel(ram_sel), .can_sel(can_sel), .tgt_we(tgt_we), .tgt_addr(tgt_addr),
        .tgt_wdata(tgt_wdata), .ram_rdata(ram_rdata), .can_rdata(can_rdata),
        .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n), .ext_oe(ext_oe), .ext_addr(ext_addr),
        .ext_dout(ext_dout), .ext_din(ext_din)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic sfr_expect(input string tag, input logic [7:0] a, input logic [7:0] exp);
        sfr_addr = a;
        #1;
        chk(tag, {24'h0, sfr_rdata}, {24'h0, exp});
    endtask

    // one transfer; exp = {ram, can, rd_n, wr_n, oe}
    task automatic movx(input string tag, input logic we, input logic [15:0] a,
                        input logic [7:0] d, input logic [4:0] exp, input logic [7:0] exp_rd);
        @(negedge clk);
        mx_req = 1'b1; mx_we = we; mx_addr = a; mx_wdata = d;
        @(negedge clk);
        mx_req = 1'b0;
        chk({tag, " sel/strobes"}, {27'h0, ram_sel, can_sel, ext_rd_n, ext_wr_n, ext_oe}, {27'h0, exp});
        if (!we) chk({tag, " rdata"}, {24'h0, mx_rdata}, {24'h0, exp_rd});
        if (we && (exp[4] || exp[3])) begin
            chk({tag, " R10 tgt_we"}, {31'h0, tgt_we}, 32'h1);
            chk({tag, " R10 tgt_wdata"}, {24'h0, tgt_wdata}, {24'h0, d});
        end
        if (exp[4] || exp[3]) chk({tag, " R10 tgt_addr"}, {16'h0, tgt_addr}, {16'h0, a});
        if (exp[0]) begin
            chk({tag, " ext_addr"}, {16'h0, ext_addr}, {16'h0, a});
            if (we) chk({tag, " ext_dout"}, {24'h0, ext_dout}, {24'h0, d});
        end
        @(negedge clk);
        chk({tag, " R9 idle after"}, {27'h0, ram_sel, can_sel, ext_rd_n, ext_wr_n, ext_oe},
            {27'h0, 5'b00110});
    endtask

    task automatic t_reset();
        do_reset();
        sfr_expect("R1 reset value", 8'hB1, 8'h01);
        chk("R1 idle outputs", {27'h0, ram_sel, can_sel, ext_rd_n, ext_wr_n, ext_oe}, {27'h0, 5'b00110});
    endtask

    task automatic t_disabled();
        movx("R4 in-window read", 1'b0, 16'hF800, 8'h00, 5'b00011, 8'h5A);
        movx("R4 peripheral write", 1'b1, 16'hF710, 8'h21, 5'b00101, 8'h00);
        sfr_write(8'hB1, 8'h03);
        sfr_expect("R8 mirror set while disabled", 8'hB1, 8'h03);
        movx("R8 disabled with mirror", 1'b0, 16'hF900, 8'h00, 5'b00011, 8'h5A);
    endtask

    task automatic t_enabled();
        sfr_write(8'hB1, 8'h00);
        sfr_expect("R3 cleared", 8'hB1, 8'h00);
        movx("R5 ram read", 1'b0, 16'hF900, 8'h00, 5'b10110, 8'hA5);
        movx("R5 can write", 1'b1, 16'hF712, 8'h77, 5'b01110, 8'h00);
        movx("R5 ram top", 1'b0, 16'hFFFF, 8'h00, 5'b10110, 8'hA5);
        movx("R5 can base", 1'b0, 16'hF700, 8'h00, 5'b01110, 8'h3C);
        movx("R5 ram base", 1'b1, 16'hF800, 8'h9C, 5'b10110, 8'h00);
        movx("R6 below window", 1'b0, 16'hF6FF, 8'h00, 5'b00011, 8'h5A);
        movx("R6 low address write", 1'b1, 16'h1234, 8'h66, 5'b00101, 8'h00);
    endtask

    task automatic t_sticky_mirror();
        sfr_write(8'hB1, 8'h03);
        sfr_expect("R3 bit0 stays clear", 8'hB1, 8'h02);
        movx("R7 mirrored ram read", 1'b0, 16'hFA00, 8'h00, 5'b10011, 8'hA5);
        movx("R7 mirrored can write", 1'b1, 16'hF7AA, 8'h44, 5'b01101, 8'h00);
        movx("R8 mirror outside window", 1'b0, 16'h0100, 8'h00, 5'b00011, 8'h5A);
    endtask

    task automatic t_register();
        sfr_write(8'hB1, 8'hFF);
        sfr_expect("R2 stored bits", 8'hB1, 8'h7E);
        sfr_expect("R2 other address reads 0", 8'hB0, 8'h00);
        sfr_write(8'hB2, 8'h00);
        sfr_expect("R2 foreign write ignored", 8'hB1, 8'h7E);
        sfr_write(8'hB1, 8'hA8);
        sfr_expect("R2 pattern", 8'hB1, 8'h28);
        do_reset();
        sfr_expect("R3 reset restores bit0", 8'hB1, 8'h01);
    endtask

    task automatic t_back_to_back();
        sfr_write(8'hB1, 8'h00);
        @(negedge clk);
        mx_req = 1'b1; mx_we = 1'b0; mx_addr = 16'hF805;
        @(negedge clk);
        chk("R9 first of pair", {30'h0, ram_sel, ext_rd_n}, {30'h0, 2'b11});
        mx_addr = 16'h0042;
        @(negedge clk);
        mx_req = 1'b0;
        chk("R9 second of pair", {30'h0, ram_sel, ext_rd_n}, {30'h0, 2'b00});
        @(negedge clk);
        chk("R9 idle after pair", {30'h0, ram_sel, ext_rd_n}, {30'h0, 2'b01});
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_enabled();
        t_sticky_mirror();
        t_register();
        t_back_to_back();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule